// File: doc/BRIEF.md
# Health Test Alert Aggregator

This block sits behind a bank of four entropy health tests (repetition count, adaptive proportion, bucket and Markov). At each window boundary every test presents a high-threshold and a low-threshold fail pulse. The block qualifies those pulses with per-test enables and decides whether the window failed. It keeps a saturating total of failing windows and a saturating tally per test. It also tracks the current run of back-to-back failing windows.

When that run reaches a programmable threshold, a sticky alert is raised and a one-cycle health-test-failed interrupt is issued. A threshold of zero switches alerting off entirely. A clear input returns all counters, the run and the alert to zero. The threshold is normally programmed to 2, so that two consecutive failing windows raise the alert.

Top module: `ht_alert_agg`

## Requirements
- R1: After the synchronous reset, the total count, every per-test count, the alert and the interrupt are all zero.
- R2: On a cycle with `win_end_i` high, the window fails if any test whose enable bit is 1 shows a high or a low fail pulse. `total_fails_o` then rises by exactly one on the next clock, however many tests failed.
- R3: Test k owns field `test_fails_o[k*CNT_W +: CNT_W]`, with k=0 repetition count, 1 adaptive proportion, 2 bucket and 3 Markov. The field rises by one for a window in which enabled test k shows a high or low fail pulse.
- R4: A test whose enable bit is 0 adds nothing to its own count, to the total or to the run of failing windows.
- R5: Fail pulses on cycles without `win_end_i` change no count and no output.
- R6: The run counter rises by one on each failing window and returns to zero at the end of a window without failure. The alert is raised when the run reaches `alert_thresh_i`, so with a threshold of 2, two failing windows back to back raise it.
- R7: With `alert_thresh_i` equal to 0, neither the alert nor the interrupt is ever raised.
- R8: Once raised, the alert stays high until clear is applied, whatever later windows show.
- R9: `intr_o` is a one-cycle pulse. It appears in the same cycle as the count update for each failing window whose run count is at or above a nonzero threshold.
- R10: The total count, the per-test counts and the run counter saturate at 2^CNT_W-1 instead of wrapping.
- R11: `clear_i` zeroes all counts, the run and the alert on the next clock. It takes priority over a window end in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_end_i | input | 1 | Window boundary strobe; the fail pulses are sampled with it |
| fail_hi_i | input | NUM_TESTS | High-threshold fail pulse per test |
| fail_lo_i | input | NUM_TESTS | Low-threshold fail pulse per test |
| test_en_i | input | NUM_TESTS | Per-test enable |
| alert_thresh_i | input | CNT_W | Consecutive failing windows needed for the alert; 0 disables it |
| clear_i | input | 1 | Clears counts, run and alert |
| alert_o | output | 1 | Sticky alert |
| intr_o | output | 1 | Health-test-failed interrupt pulse |
| total_fails_o | output | CNT_W | Saturating count of failing windows |
| test_fails_o | output | NUM_TESTS*CNT_W | Per-test saturating fail counts, test k at bits k*CNT_W upward |

## Verification
The assertions take for granted that the fail pulses matter only in a cycle where `win_end_i` is high. They also take for granted that the threshold is stable from the window end that raises the alert until the cycle after it. The stimulus drives every input one half-cycle ahead of the sampling edge and holds the threshold across each window. The sweep covers every combination of high pulses, low pulses and enables with thresholds 0 to 3. It also applies clears together with window ends and runs enough failing windows to saturate the narrowed counters.

// File: rtl/ht_alert_pkg.sv
package ht_alert_pkg;
  typedef enum int {
    HT_REPCNT = 0,
    HT_ADAPT  = 1,
    HT_BUCKET = 2,
    HT_MARKOV = 3
  } ht_test_e;

  localparam int HT_NUM_TESTS = 4;
  localparam int HT_CNT_W     = 16;
endpackage

// File: rtl/ht_sat_counter.sv
module ht_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_o <= '0;
    end else if (inc && cnt_o != MAXV) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ht_run_tracker.sv
module ht_run_tracker #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         win_end,
  input  logic         win_fail,
  input  logic [W-1:0] thresh,
  output logic         alert_o,
  output logic         intr_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] run_q;
  logic [W-1:0] run_nx;
  logic         reach;

  always_comb begin
    run_nx = (run_q == MAXV) ? run_q : run_q + 1'b1;
    reach  = (thresh != '0) && (run_nx >= thresh);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q   <= '0;
      alert_o <= 1'b0;
      intr_o  <= 1'b0;
    end else begin
      intr_o <= 1'b0;
      if (win_end) begin
        if (win_fail) begin
          run_q <= run_nx;
          if (reach) begin
            alert_o <= 1'b1;
            intr_o  <= 1'b1;
          end
        end else begin
          run_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ht_alert_agg.sv
module ht_alert_agg #(
  parameter int NUM_TESTS = ht_alert_pkg::HT_NUM_TESTS,
  parameter int CNT_W     = ht_alert_pkg::HT_CNT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       win_end_i,
  input  logic [NUM_TESTS-1:0]       fail_hi_i,
  input  logic [NUM_TESTS-1:0]       fail_lo_i,
  input  logic [NUM_TESTS-1:0]       test_en_i,
  input  logic [CNT_W-1:0]           alert_thresh_i,
  input  logic                       clear_i,
  output logic                       alert_o,
  output logic                       intr_o,
  output logic [CNT_W-1:0]           total_fails_o,
  output logic [NUM_TESTS*CNT_W-1:0] test_fails_o
);
  logic [NUM_TESTS-1:0] test_hit;
  logic                 win_fail;

  always_comb begin
    test_hit = (fail_hi_i | fail_lo_i) & test_en_i & {NUM_TESTS{win_end_i}};
    win_fail = |test_hit;
  end

  for (genvar k = 0; k < NUM_TESTS; k++) begin : g_test
    ht_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (clear_i),
      .inc   (test_hit[k]),
      .cnt_o (test_fails_o[k*CNT_W +: CNT_W])
    );
  end

  ht_sat_counter #(.W(CNT_W)) u_total (
    .clk   (clk),
    .rst   (rst),
    .clr   (clear_i),
    .inc   (win_fail),
    .cnt_o (total_fails_o)
  );

  ht_run_tracker #(.W(CNT_W)) u_run (
    .clk      (clk),
    .rst      (rst),
    .clr      (clear_i),
    .win_end  (win_end_i),
    .win_fail (win_fail),
    .thresh   (alert_thresh_i),
    .alert_o  (alert_o),
    .intr_o   (intr_o)
  );
endmodule

// File: rtl/ht_alert_agg_chk.sv
module ht_alert_agg_chk #(
  parameter int NUM_TESTS = 4,
  parameter int CNT_W     = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       win_end_i,
  input logic [CNT_W-1:0]           alert_thresh_i,
  input logic                       clear_i,
  input logic                       alert_o,
  input logic                       intr_o,
  input logic [CNT_W-1:0]           total_fails_o,
  input logic [NUM_TESTS*CNT_W-1:0] test_fails_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  assert_alert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (alert_o && !clear_i) |=> alert_o);

  assert_zero_thresh_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_o) |-> ($past(alert_thresh_i) != '0));

  assert_intr_on_window_R9: assert property (@(posedge clk) disable iff (rst)
    intr_o |-> ($past(win_end_i) && !$past(clear_i) && alert_o));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && total_fails_o == MAXV) |=> (total_fails_o == MAXV));

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (total_fails_o == '0 && test_fails_o == '0 && !alert_o));

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!win_end_i && !clear_i) |=> ($stable(total_fails_o) && $stable(test_fails_o) && !intr_o));
endmodule

bind ht_alert_agg ht_alert_agg_chk #(.NUM_TESTS(NUM_TESTS), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .win_end_i      (win_end_i),
  .alert_thresh_i (alert_thresh_i),
  .clear_i        (clear_i),
  .alert_o        (alert_o),
  .intr_o         (intr_o),
  .total_fails_o  (total_fails_o),
  .test_fails_o   (test_fails_o)
);

// File: tb/tb_ht_alert_agg.sv
module tb_ht_alert_agg;
  localparam int NT = 4;
  localparam int W  = 6;
  localparam int MAXV = (1 << W) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            win_end_i = 1'b0;
  logic [NT-1:0]   fail_hi_i = '0;
  logic [NT-1:0]   fail_lo_i = '0;
  logic [NT-1:0]   test_en_i = '1;
  logic [W-1:0]    alert_thresh_i = W'(2);
  logic            clear_i = 1'b0;
  logic            alert_o;
  logic            intr_o;
  logic [W-1:0]    total_fails_o;
  logic [NT*W-1:0] test_fails_o;

  int checks = 0;
  int errors = 0;
  int m_tot = 0;
  int m_run = 0;
  int m_alert = 0;
  int m_intr = 0;
  int m_test [NT];

  always #4 clk = ~clk;

  ht_alert_agg #(.NUM_TESTS(NT), .CNT_W(W)) dut (
    .clk(clk), .rst(rst), .win_end_i(win_end_i), .fail_hi_i(fail_hi_i),
    .fail_lo_i(fail_lo_i), .test_en_i(test_en_i), .alert_thresh_i(alert_thresh_i),
    .clear_i(clear_i), .alert_o(alert_o), .intr_o(intr_o),
    .total_fails_o(total_fails_o), .test_fails_o(test_fails_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 total", int'(total_fails_o), m_tot);
    for (int k = 0; k < NT; k++)
      chk("R3 per-test", int'(test_fails_o[k*W +: W]), m_test[k]);
    chk("R6/R8 alert", int'(alert_o), m_alert);
    chk("R9 intr", int'(intr_o), m_intr);
  endtask

  task automatic model_clear();
    m_tot = 0; m_run = 0; m_alert = 0; m_intr = 0;
    for (int k = 0; k < NT; k++) m_test[k] = 0;
  endtask

  task automatic win(input logic [NT-1:0] hi, input logic [NT-1:0] lo,
                     input logic [NT-1:0] en, input int thr, input bit clr);
    logic [NT-1:0] f;
    @(negedge clk);
    fail_hi_i = hi; fail_lo_i = lo; test_en_i = en;
    alert_thresh_i = W'(thr); clear_i = clr; win_end_i = 1'b1;
    if (clr) begin
      model_clear();
    end else begin
      f = (hi | lo) & en;
      m_intr = 0;
      for (int k = 0; k < NT; k++)
        if (f[k] && m_test[k] < MAXV) m_test[k]++;
      if (f != '0) begin
        if (m_tot < MAXV) m_tot++;
        if (m_run < MAXV) m_run++;
        if (thr != 0 && m_run >= thr) begin m_alert = 1; m_intr = 1; end
      end else begin
        m_run = 0;
      end
    end
    @(negedge clk);
    win_end_i = 1'b0; clear_i = 1'b0; fail_hi_i = '0; fail_lo_i = '0;
    cmp_all();
    m_intr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 total", int'(total_fails_o), 0);
    chk("R1 tests", int'(test_fails_o), 0);
    chk("R1 alert", int'(alert_o), 0);
    chk("R1 intr", int'(intr_o), 0);

    // R5 pulses without a window end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      fail_hi_i = '1; fail_lo_i = '1;
    end
    @(negedge clk);
    fail_hi_i = '0; fail_lo_i = '0;
    @(negedge clk);
    chk("R5 total", int'(total_fails_o), 0);
    chk("R5 tests", int'(test_fails_o), 0);
    chk("R5 intr", int'(intr_o), 0);

    // R6 threshold 2: two consecutive failing windows
    win(4'b0001, 4'b0000, 4'hF, 2, 1'b0);
    chk("R6 alert after one", int'(alert_o), 0);
    win(4'b0000, 4'b1000, 4'hF, 2, 1'b0);
    chk("R6 alert after two", int'(alert_o), 1);
    chk("R9 intr on reach", int'(intr_o), 1);

    // R8 stays up through passing windows
    for (int i = 0; i < 3; i++) win(4'b0000, 4'b0000, 4'hF, 2, 1'b0);
    chk("R8 sticky", int'(alert_o), 1);

    // R11 clear with simultaneous failing window end
    win(4'hF, 4'hF, 4'hF, 2, 1'b1);
    chk("R11 total", int'(total_fails_o), 0);
    chk("R11 alert", int'(alert_o), 0);

    // R6 run broken by a passing window
    win(4'b0010, 4'b0000, 4'hF, 2, 1'b0);
    win(4'b0000, 4'b0000, 4'hF, 2, 1'b0);
    win(4'b0100, 4'b0000, 4'hF, 2, 1'b0);
    chk("R6 run reset", int'(alert_o), 0);

    // R7 threshold zero
    win(4'h0, 4'h0, 4'hF, 0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      win(4'hF, 4'h0, 4'hF, 0, 1'b0);
      chk("R7 intr", int'(intr_o), 0);
    end
    chk("R7 alert", int'(alert_o), 0);

    // R4 disabled tests
    win(4'h0, 4'h0, 4'hF, 3, 1'b1);
    win(4'hF, 4'hF, 4'h0, 1, 1'b0);
    chk("R4 total", int'(total_fails_o), 0);
    chk("R4 alert", int'(alert_o), 0);
    win(4'b0101, 4'b1010, 4'b0011, 1, 1'b0);
    chk("R4 masked tests", int'(test_fails_o[2*W +: W]) + int'(test_fails_o[3*W +: W]), 0);

    // R10 saturation
    win(4'h0, 4'h0, 4'hF, 0, 1'b1);
    for (int i = 0; i < MAXV + 7; i++) win(4'hF, 4'h0, 4'hF, 0, 1'b0);
    chk("R10 total", int'(total_fails_o), MAXV);
    chk("R10 test0", int'(test_fails_o[0 +: W]), MAXV);

    // Sweep: every enable/hi/lo combination, thresholds 0..3
    for (int e = 0; e < 16; e++) begin
      win(4'h0, 4'h0, 4'hF, e % 4, 1'b1);
      for (int h = 0; h < 16; h++)
        for (int l = 0; l < 16; l++)
          win(NT'(h), NT'(l), NT'(e), e % 4, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule